// File: doc/BRIEF.md
# Three-Stage Fetch/Decode/Execute Sequencer

This block steers the instruction flow of a processor core that runs either full-width (32-bit) or half-width (16-bit) instructions. It has three slots. On every clock it fetches a word at the program counter. The word fetched on the previous clock moves into the decode slot, and the word that was in the decode slot is presented to the execute stage. The block does not track each slot with its own valid bit. It uses a three-state machine instead: two refill steps and then a steady execute state. A reset or a pipeline flush always restarts the machine from the first refill step.

The execute stage receives a strobe together with the instruction word and that word's address. It can request a flush with a new target address, for example on a taken branch or an exception. The flush also selects the instruction width to use from that point on. Words that are still in the slots when a flush arrives never reach execute, so an illegal encoding placed just after a branch never produces an error. The block also reports the address of the instruction that will execute next, which a debugger or an exception unit can use.

Top module: `fetch_pipe_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the block is in the first refill step. `fetchAddr` and `nextAddr` equal `RESET_ADDR`, `exValid` is 0, and the width is the one chosen by `RESET_NARROW`.
- R2: After a reset or a flush, `exValid` stays low for exactly two cycles (the two refill steps). It is high on the third cycle and on every later cycle, unless another flush arrives.
- R3: On any cycle without `flushReq`, `fetchAddr` advances by 4 on the next cycle in full-width mode and by 2 in half-width mode, wrapping modulo 2^ADDR_W.
- R4: While `exValid` is high, `exInsn` is the word that was fetched two cycles earlier, and `exAddr` equals `fetchAddr` minus two instruction sizes (minus 8 in full-width mode, minus 4 in half-width mode).
- R5: A `flushReq` sampled on a clock edge loads `flushTarget` into the program counter and returns the machine to the first refill step. This also happens in a refill step, and it takes priority over the normal increment in the execute state.
- R6: `nextAddr` equals the program counter in the first refill step, the program counter minus one instruction size in the second refill step, and the program counter minus two instruction sizes in the execute state.
- R7: In half-width mode, only the low half of `fetchData` is kept. `exInsn` carries it in bits 15:0 with the upper half zero.
- R8: `illegalInsn` is high exactly on cycles where `exValid` and `illegalIn` are both high. `illegalIn` has no effect on any cycle without `exValid`.
- R9: `narrowSel` is taken into the width only on a cycle that has `flushReq`. A change of `narrowSel` without a flush does not change the step size.
- R10: While `exValid` is low, `exInsn` and `exAddr` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchData | input | INSN_W | Word read at `fetchAddr` in the same cycle |
| narrowSel | input | 1 | Width for the flush target: 1 = half-width, 0 = full-width |
| flushReq | input | 1 | Flush request from the execute stage |
| flushTarget | input | ADDR_W | New program counter applied on a flush |
| illegalIn | input | 1 | External decode flag for the word on `exInsn` |
| fetchAddr | output | ADDR_W | Address of the current fetch (the program counter) |
| exValid | output | 1 | An instruction executes this cycle |
| exInsn | output | INSN_W | Word being executed |
| exAddr | output | ADDR_W | Address of the word being executed |
| illegalInsn | output | 1 | The executing word is illegal |
| nextAddr | output | ADDR_W | Address of the next instruction to execute |

## Verification
The bench builds the block with ADDR_W = 32 and INSN_W = 32, uses RESET_ADDR = 0x100, and starts in full-width mode. With these values both instruction sizes are exercised, since a flush switches to half-width mode and a later flush switches back. A flush to 0xFFFFFFFC makes the program counter wrap through zero during the refill steps. The memory model returns the complemented low half of the address in its upper half, so a half-width word shows any upper bits that leak through.

// File: rtl/fetch_pipe_pkg.sv
package fetch_pipe_pkg;

  typedef enum logic [1:0] {
    ST_FILL_A = 2'd0,
    ST_FILL_B = 2'd1,
    ST_RUN    = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadTarget;  // take flush target and width
    logic       stepPc;      // advance by one instruction size
    logic       issue;       // decode slot is handed to execute
    logic [1:0] lagSteps;    // sizes between pc and next-to-execute
  } seqCtrl_t;

endpackage

// File: rtl/fetch_pipe_ctrl.sv
module fetch_pipe_ctrl
  import fetch_pipe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     flushReq,
  output seqCtrl_t ctrl
);

  seqState_t stateQ, stateD;

  always_comb begin
    unique case (stateQ)
      ST_FILL_A: stateD = ST_FILL_B;
      ST_FILL_B: stateD = ST_RUN;
      default:   stateD = ST_RUN;
    endcase
    if (flushReq) stateD = ST_FILL_A;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_FILL_A;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctrl.loadTarget = flushReq;
    ctrl.stepPc     = !flushReq;
    ctrl.issue      = (stateQ == ST_RUN);
    unique case (stateQ)
      ST_FILL_A: ctrl.lagSteps = 2'd0;
      ST_FILL_B: ctrl.lagSteps = 2'd1;
      default:   ctrl.lagSteps = 2'd2;
    endcase
  end

endmodule

// File: rtl/fetch_pipe_dp.sv
module fetch_pipe_dp
  import fetch_pipe_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned INSN_W       = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter bit          RESET_NARROW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [INSN_W-1:0] fetchData,
  input  logic              narrowSel,
  input  logic [ADDR_W-1:0] flushTarget,
  input  logic              illegalIn,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              exValid,
  output logic [INSN_W-1:0] exInsn,
  output logic [ADDR_W-1:0] exAddr,
  output logic              illegalInsn,
  output logic [ADDR_W-1:0] nextAddr
);

  localparam int unsigned HALF_W       = INSN_W / 2;
  localparam int unsigned WIDE_BYTES   = INSN_W / 8;
  localparam int unsigned NARROW_BYTES = WIDE_BYTES / 2;

  logic [ADDR_W-1:0] pcQ;
  logic              narrowQ;
  logic [INSN_W-1:0] fetchSlotQ, decodeSlotQ;
  logic [INSN_W-1:0] fetchWord;
  logic [ADDR_W-1:0] stepBytes;

  assign stepBytes = narrowQ ? ADDR_W'(NARROW_BYTES) : ADDR_W'(WIDE_BYTES);
  assign fetchWord = narrowQ ? {{(INSN_W-HALF_W){1'b0}}, fetchData[HALF_W-1:0]} : fetchData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ         <= RESET_ADDR;
      narrowQ     <= RESET_NARROW;
      fetchSlotQ  <= '0;
      decodeSlotQ <= '0;
    end else begin
      fetchSlotQ  <= fetchWord;
      decodeSlotQ <= fetchSlotQ;
      if (ctrl.loadTarget) begin
        pcQ     <= flushTarget;
        narrowQ <= narrowSel;
      end else if (ctrl.stepPc) begin
        pcQ <= pcQ + stepBytes;
      end
    end
  end

  always_comb begin
    unique case (ctrl.lagSteps)
      2'd0:    nextAddr = pcQ;
      2'd1:    nextAddr = pcQ - stepBytes;
      default: nextAddr = pcQ - (stepBytes << 1);
    endcase
  end

  assign fetchAddr   = pcQ;
  assign exValid     = ctrl.issue;
  assign exInsn      = ctrl.issue ? decodeSlotQ : '0;
  assign exAddr      = ctrl.issue ? pcQ - (stepBytes << 1) : '0;
  assign illegalInsn = ctrl.issue & illegalIn;

endmodule

// File: rtl/fetch_pipe_seq.sv
module fetch_pipe_seq
  import fetch_pipe_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned INSN_W       = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter bit          RESET_NARROW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INSN_W-1:0] fetchData,
  input  logic              narrowSel,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] flushTarget,
  input  logic              illegalIn,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              exValid,
  output logic [INSN_W-1:0] exInsn,
  output logic [ADDR_W-1:0] exAddr,
  output logic              illegalInsn,
  output logic [ADDR_W-1:0] nextAddr
);

  seqCtrl_t ctrl;

  fetch_pipe_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flushReq (flushReq),
    .ctrl     (ctrl)
  );

  fetch_pipe_dp #(
    .ADDR_W       (ADDR_W),
    .INSN_W       (INSN_W),
    .RESET_ADDR   (RESET_ADDR),
    .RESET_NARROW (RESET_NARROW)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .fetchData   (fetchData),
    .narrowSel   (narrowSel),
    .flushTarget (flushTarget),
    .illegalIn   (illegalIn),
    .fetchAddr   (fetchAddr),
    .exValid     (exValid),
    .exInsn      (exInsn),
    .exAddr      (exAddr),
    .illegalInsn (illegalInsn),
    .nextAddr    (nextAddr)
  );

endmodule

// File: rtl/fetch_pipe_seq_chk.sv
module fetch_pipe_seq_chk #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned INSN_W       = 32,
  parameter bit          RESET_NARROW = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              narrowSel,
  input logic              flushReq,
  input logic [ADDR_W-1:0] flushTarget,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              exValid,
  input logic [INSN_W-1:0] exInsn,
  input logic [ADDR_W-1:0] exAddr,
  input logic              illegalInsn,
  input logic [ADDR_W-1:0] nextAddr
);

  localparam int unsigned WIDE_BYTES = INSN_W / 8;

  // width seen from the ports: only a flush may change it
  logic              modeNarrow;
  logic [ADDR_W-1:0] stepB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeNarrow <= RESET_NARROW;
    else if (flushReq) modeNarrow <= narrowSel;
  end

  assign stepB = modeNarrow ? ADDR_W'(WIDE_BYTES / 2) : ADDR_W'(WIDE_BYTES);

  assert_refill_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !exValid ##1 !exValid);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flushReq |=> fetchAddr == $past(fetchAddr) + stepB);

  assert_ex_addr_lag_R4: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> exAddr == fetchAddr - (stepB << 1));

  assert_flush_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> fetchAddr == $past(flushTarget));

  assert_next_matches_exec_R6: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> nextAddr == exAddr);

  assert_no_squash_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    !exValid |-> !illegalInsn);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !exValid |-> (exInsn == '0 && exAddr == '0));

endmodule

bind fetch_pipe_seq fetch_pipe_seq_chk #(
  .ADDR_W       (ADDR_W),
  .INSN_W       (INSN_W),
  .RESET_NARROW (RESET_NARROW)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .narrowSel   (narrowSel),
  .flushReq    (flushReq),
  .flushTarget (flushTarget),
  .fetchAddr   (fetchAddr),
  .exValid     (exValid),
  .exInsn      (exInsn),
  .exAddr      (exAddr),
  .illegalInsn (illegalInsn),
  .nextAddr    (nextAddr)
);

// File: tb/test_fetch_pipe_seq.sv
`timescale 1ns/1ps
module test_fetch_pipe_seq;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned INSN_W = 32;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam int NROWS = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              narrowSel = 1'b0;
  logic              flushReq = 1'b0;
  logic [ADDR_W-1:0] flushTarget = '0;
  logic              illegalIn = 1'b0;
  logic [INSN_W-1:0] fetchData;
  logic [ADDR_W-1:0] fetchAddr, exAddr, nextAddr;
  logic [INSN_W-1:0] exInsn;
  logic              exValid, illegalInsn;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  // memory model: upper half is the complemented low address half
  assign fetchData = {~fetchAddr[15:0], fetchAddr[15:0]};

  fetch_pipe_seq #(
    .ADDR_W       (ADDR_W),
    .INSN_W       (INSN_W),
    .RESET_ADDR   (RST_PC),
    .RESET_NARROW (1'b0)
  ) i_fetch_pipe_seq (
    .clk         (clk),
    .rstN        (rstN),
    .fetchData   (fetchData),
    .narrowSel   (narrowSel),
    .flushReq    (flushReq),
    .flushTarget (flushTarget),
    .illegalIn   (illegalIn),
    .fetchAddr   (fetchAddr),
    .exValid     (exValid),
    .exInsn      (exInsn),
    .exAddr      (exAddr),
    .illegalInsn (illegalInsn),
    .nextAddr    (nextAddr)
  );

  // {flush, target, narrow, illIn, expValid, expIll, expFetch, expNext, expInsn}
  localparam logic [132:0] VEC [NROWS] = '{
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0100, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0104, 32'h0000_0100, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0108, 32'h0000_0100, 32'hFEFF_0100},
    {1'b1, 32'h200,      1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_010C, 32'h0000_0104, 32'hFEFB_0104},
    {1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0200, 32'h0000_0200, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0202, 32'h0000_0200, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0204, 32'h0000_0200, 32'h0000_0200},
    {1'b1, 32'h300,      1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0206, 32'h0000_0202, 32'h0000_0202},
    {1'b1, 32'h400,      1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0300, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0400, 32'h0000_0400, 32'h0},
    {1'b1, 32'hFFFFFFFC, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0404, 32'h0000_0400, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0004, 32'hFFFF_FFFC, 32'h0003_FFFC},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0008, 32'h0000_0000, 32'hFFFF_0000},
    {1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_000C, 32'h0000_0004, 32'hFFFB_0004}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: state held in reset
    @(negedge clk);
    #1;
    chk("R1 fetchAddr in reset", fetchAddr, RST_PC);
    chk("R1 exValid in reset", {31'b0, exValid}, 32'd0);
    chk("R1 nextAddr in reset", nextAddr, RST_PC);
    rstN = 1'b1;

    // table walk: rows 3,7 flush in execute (R5 priority), 8,10 flush in refill,
    // rows 4..6 half-width (R7) with narrowSel low and no flush (R9)
    for (int i = 0; i < NROWS; i++) begin
      logic [132:0] v;
      logic [31:0]  expAddr;
      v = VEC[i];
      if (i != 0) @(negedge clk);
      flushReq    = v[132];
      flushTarget = v[131:100];
      narrowSel   = v[99];
      illegalIn   = v[98];
      #1;
      expAddr = v[97] ? v[63:32] : 32'h0;
      chk($sformatf("R2 exValid row %0d", i), {31'b0, exValid}, {31'b0, v[97]});
      chk($sformatf("R8 illegalInsn row %0d", i), {31'b0, illegalInsn}, {31'b0, v[96]});
      chk($sformatf("R3/R5/R9 fetchAddr row %0d", i), fetchAddr, v[95:64]);
      chk($sformatf("R6 nextAddr row %0d", i), nextAddr, v[63:32]);
      chk($sformatf("R4/R7/R10 exInsn row %0d", i), exInsn, v[31:0]);
      chk($sformatf("R4/R10 exAddr row %0d", i), exAddr, expAddr);
    end

    // directed: reset in the middle of a run returns to the start (R1)
    @(negedge clk);
    flushReq  = 1'b0;
    illegalIn = 1'b0;
    rstN      = 1'b0;
    #1;
    chk("R1 fetchAddr after mid-run reset", fetchAddr, RST_PC);
    chk("R1 exValid after mid-run reset", {31'b0, exValid}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 nextAddr first cycle", nextAddr, RST_PC);
    @(negedge clk);
    #1;
    chk("R3 full-width step after reset", fetchAddr, RST_PC + 32'd4);
    chk("R2 second refill quiet", {31'b0, exValid}, 32'd0);
    @(negedge clk);
    #1;
    chk("R2 execute starts on third cycle", {31'b0, exValid}, 32'd1);
    chk("R4 first word after reset", exInsn, {~RST_PC[15:0], RST_PC[15:0]});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule